// File: doc/BRIEF.md
# Bus Acknowledge Timeout Watchdog

This block guards processor bus cycles aimed at modules outside the processor's own address space. When a cycle starts with the external qualifier set, the block opens a timeout window that lasts a fixed number of clock cycles. An acknowledge from the addressed module inside that window closes the window quietly. If no acknowledge comes, the block does two things at once. It latches an acknowledge-failure interrupt request, which is the most urgent of the internal interrupt sources. It also emits a one-cycle substitute acknowledge, so that the processor leaves its wait state instead of stalling forever.

The window length is the parameter `TIMEOUT_CYCLES`, counted in clock cycles by a synchronous counter. The interrupt request stays high until software pulses the clear input. No new window can open while a timeout interrupt is still waiting to be cleared.

Top module: `bus_ack_wdog`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it is released, both outputs are low and no window is open. Asserting reset in the middle of a window cancels it, so no interrupt follows.
- R2: A window opens only on a clock edge where `sync_i` and `ext_sel_i` are both 1. A strobe with `ext_sel_i` = 0 has no effect on either output.
- R3: If `ack_i` is sampled high on any of the edges 1 to `TIMEOUT_CYCLES` after the opening edge, the window closes and neither output is raised for that cycle.
- R4: If `ack_i` stays low through edge `TIMEOUT_CYCLES` after the opening edge, `ack_fail_irq_o` goes high right after that edge.
- R5: On a timeout, `wait_release_o` goes high for exactly one cycle, in the same cycle in which `ack_fail_irq_o` rises. It is never high at any other time.
- R6: Once high, `ack_fail_irq_o` stays high until an edge samples `irq_clr_i` = 1, and it is low after that edge. If a timeout and a clear land on the same edge, the interrupt stays set.
- R7: A `sync_i` strobe during an open window does not restart it. The timeout still falls `TIMEOUT_CYCLES` edges after the first opening edge.
- R8: While `ack_fail_irq_o` is high, a strobe with `ext_sel_i` = 1 opens no window. No interrupt follows it, even after the clear.
- R9: `ack_i` outside an open window is ignored. It neither raises an output nor clears a pending interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_sel_i | input | 1 | Address-space qualifier: 1 marks the cycle as external |
| sync_i | input | 1 | Cycle-start strobe |
| ack_i | input | 1 | Acknowledge from the addressed external module |
| irq_clr_i | input | 1 | Clear pulse for the pending interrupt |
| ack_fail_irq_o | output | 1 | Acknowledge-failure interrupt request, highest internal priority |
| wait_release_o | output | 1 | One-cycle substitute acknowledge that ends the wait state |

## Verification
The bench builds the block with `TIMEOUT_CYCLES` = 5. With a window that short, the sweep can place the acknowledge on every edge from the first one to two edges past expiry, and it also covers the case with no acknowledge at all. The edge where an on-time acknowledge meets the expiry, and the first late acknowledge, are therefore both exercised. The short window also leaves room for restart strobes, strobes that arrive while an interrupt is pending, a clear that collides with a timeout, and a reset in the middle of a window, each checked against the exact cycle the requirements give.

// File: rtl/bus_ack_wdog_pkg.sv
package bus_ack_wdog_pkg;
  typedef enum logic {
    WD_IDLE = 1'b0,
    WD_WAIT = 1'b1
  } wd_state_e;
endpackage

// File: rtl/bus_ack_wdog_timer.sv
module bus_ack_wdog_timer #(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CNT_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  generate
    if (TIMEOUT_CYCLES == 1) begin : g_single
      // Window is one edge long: any running edge expires.
      assign expire_o = run_i;
    end else begin : g_count
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else if (start_i) begin
          cnt_q <= '0;
        end else if (run_i && cnt_q != LAST) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign expire_o = run_i && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/bus_ack_wdog_flag.sv
module bus_ack_wdog_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o,
  output logic rel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      rel_o <= 1'b0;
    end else begin
      rel_o <= set_i;
      if (set_i)      irq_o <= 1'b1;  // set beats clear
      else if (clr_i) irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_ack_wdog.sv
module bus_ack_wdog
  import bus_ack_wdog_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_sel_i,
  input  logic sync_i,
  input  logic ack_i,
  input  logic irq_clr_i,
  output logic ack_fail_irq_o,
  output logic wait_release_o
);
  wd_state_e state_q, state_d;
  logic      start, run, tmo_hit, busy;

  assign busy  = (state_q == WD_WAIT);
  assign start = !busy && sync_i && ext_sel_i && !ack_fail_irq_o;
  assign run   = busy && !ack_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WD_IDLE: if (start) state_d = WD_WAIT;
      WD_WAIT: if (ack_i || tmo_hit) state_d = WD_IDLE;
      default: state_d = WD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= WD_IDLE;
    else         state_q <= state_d;
  end

  bus_ack_wdog_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .run_i    (run),
    .expire_o (tmo_hit)
  );

  bus_ack_wdog_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (tmo_hit),
    .clr_i  (irq_clr_i),
    .irq_o  (ack_fail_irq_o),
    .rel_o  (wait_release_o)
  );
endmodule

// File: rtl/bus_ack_wdog_chk.sv
module bus_ack_wdog_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ack_i,
  input logic irq_clr_i,
  input logic ack_fail_irq_o,
  input logic wait_release_o,
  input logic busy,
  input logic tmo_hit
);
  a_r4_timeout_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_hit |=> ack_fail_irq_o && wait_release_o);

  a_r3_ack_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && ack_i |=> !busy && !wait_release_o);

  a_r5_release_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_release_o |=> !wait_release_o);

  a_r5_release_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_release_o |-> ack_fail_irq_o);

  a_r5_irq_rise_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_fail_irq_o) |-> wait_release_o);

  a_r6_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fail_irq_o && !irq_clr_i |=> ack_fail_irq_o);

  a_r6_irq_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i && !tmo_hit |=> !ack_fail_irq_o);

  a_r8_no_window_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fail_irq_o |-> !busy);
endmodule

bind bus_ack_wdog bus_ack_wdog_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ack_i          (ack_i),
  .irq_clr_i      (irq_clr_i),
  .ack_fail_irq_o (ack_fail_irq_o),
  .wait_release_o (wait_release_o),
  .busy           (busy),
  .tmo_hit        (tmo_hit)
);

// File: tb/bus_ack_wdog_bench.sv
`timescale 1ns/1ps
module bus_ack_wdog_bench;
  localparam int T = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_sel = 1'b0, sync = 1'b0, ack = 1'b0, clr = 1'b0;
  logic irq, rel;
  int   n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  bus_ack_wdog #(.TIMEOUT_CYCLES(T)) u_bus_ack_wdog (
    .clk_i (clk), .rst_ni (rst_n), .ext_sel_i (ext_sel), .sync_i (sync),
    .ack_i (ack), .irq_clr_i (clr), .ack_fail_irq_o (irq), .wait_release_o (rel)
  );

  task automatic chk(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, irq, 1'b0);
      chk(req, rel, 1'b0);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R6 clear", irq, 1'b0);
  endtask

  // ack on edge d after the opening edge; d == 0 means none
  task automatic run_ack(int d);
    logic timed;
    timed = (d == 0) || (d > T);
    @(negedge clk); sync = 1'b1; ext_sel = 1'b1;
    for (int k = 1; k <= T + 3; k++) begin
      @(negedge clk);
      sync = 1'b0; ext_sel = 1'b0; ack = 1'b0;
      chk(timed ? "R5 release" : "R3 release", rel, timed && (k == T + 1));
      chk(timed ? "R4 irq" : "R3 irq", irq, timed && (k >= T + 1));
      ack = (k == d);
    end
    @(negedge clk); ack = 1'b0;
    chk("R9 late ack keeps irq", irq, timed);
    if (timed) do_clear();
  endtask

  initial begin
    #(200000 * 20);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset irq", irq, 1'b0);
    chk("R1 reset release", rel, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", irq | rel, 1'b0);

    for (int d = 0; d <= T + 2; d++) run_ack(d);

    // R2: strobe on an internal address
    @(negedge clk); sync = 1'b1; ext_sel = 1'b0;
    @(negedge clk); sync = 1'b0;
    quiet(T + 3, "R2 internal");

    // R9: ack while idle
    @(negedge clk); ack = 1'b1;
    quiet(3, "R9 idle ack");
    ack = 1'b0;

    // R7: second strobe at edge 2 must not restart
    @(negedge clk); sync = 1'b1; ext_sel = 1'b1;
    for (int k = 1; k <= T + 1; k++) begin
      @(negedge clk);
      sync = (k == 2); ext_sel = (k == 2);
      chk("R7 no restart", irq, k >= T + 1);
    end
    sync = 1'b0; ext_sel = 1'b0;
    do_clear();

    // R6: clear collides with timeout edge
    @(negedge clk); sync = 1'b1; ext_sel = 1'b1;
    for (int k = 1; k <= T; k++) begin
      @(negedge clk); sync = 1'b0; ext_sel = 1'b0;
      clr = (k == T);
    end
    @(negedge clk); clr = 1'b0;
    chk("R6 set wins", irq, 1'b1);
    repeat (3) @(negedge clk);
    chk("R6 held", irq, 1'b1);

    // R8: strobe while pending, then clear
    sync = 1'b1; ext_sel = 1'b1;
    @(negedge clk); sync = 1'b0; ext_sel = 1'b0;
    chk("R8 still pending", irq, 1'b1);
    do_clear();
    quiet(T + 3, "R8 no window");

    // R1: reset mid-window
    @(negedge clk); sync = 1'b1; ext_sel = 1'b1;
    @(negedge clk); sync = 1'b0; ext_sel = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset", irq | rel, 1'b0);
    rst_n = 1'b1;
    quiet(T + 3, "R1 cancelled");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule